// File: doc/BRIEF.md
# Return-address stack with interrupt admission control

This block keeps the return addresses of a small processor core in a fixed-depth hardware stack of program-counter values. A subroutine call strobe or an accepted interrupt pushes the current program counter. A return strobe, or a return-from-interrupt strobe, pops the newest entry, and the popped address appears on the top-of-stack output. Software has no path to read or write the entries or the level pointer.

The block also holds the interrupt requests and decides when one may be taken. A request is always latched, whatever its enable. It is accepted only when all of the following are true: its enable is set, the global enable is set, no call or return strobe is active in that cycle, and the stack has a free level. While the stack is full, the request waits in its flag. It is accepted by itself in the cycle after a pop frees a level.

Accepting an interrupt clears the global enable. A return-from-interrupt sets it again. Vector generation is left to the core, which uses the reported source index.

Top module: `rsg_top`

## Requirements
- R1: The stack holds at most 8 entries. `full_o` is high exactly when 8 entries are held.
- R2: A `call_i` strobe pushes `pc_i`. From the next cycle, `tos_o` shows that value.
- R3: A `ret_i` or `reti_i` strobe pops the newest entry. `tos_o` then shows the entry below it in last-in first-out order, or 0 once the stack is empty.
- R4: After a synchronous reset the stack is empty, `full_o`=0, `tos_o`=0, `pend_o`=0, `ack_o`=0, and the global interrupt enable is set.
- R5: A pop while the stack is empty is ignored. A following push and pop behave as on a fresh stack.
- R6: A request pulse on `irq_req_i` (bit 0 = external, bit 1 = timer 0, bit 2 = timer 1) sets `pend_o` at the next edge. If it is admissible, `ack_o` pulses one edge later. On that pulse, `ack_id_o` gives the source index, `pc_i` is pushed, and that flag is cleared.
- R7: While `full_o` is high, no interrupt is acknowledged and the flag stays set. In the cycle after a pop frees a level, the interrupt is acknowledged.
- R8: A call while the stack is full overwrites the oldest entry. `full_o` stays high and nothing else signals it.
- R9: An acknowledge clears the global enable, so no other request is accepted. `reti_i` sets the global enable again, and a waiting request is then acknowledged one cycle later.
- R10: When several enabled requests are pending, external wins over timer 0, and timer 0 wins over timer 1. Only the winner's flag is cleared.
- R11: A pending request whose `irq_en_i` bit is 0 is not acknowledged and stays in `pend_o`. It is acknowledged once its enable is set.
- R12: If `call_i` and a return strobe arrive together, the push is done and the pop is dropped. No acknowledge is taken in a cycle with any call or return strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| call_i | input | 1 | Subroutine call strobe, pushes `pc_i` |
| ret_i | input | 1 | Subroutine return strobe, pops |
| reti_i | input | 1 | Interrupt return strobe, pops and sets global enable |
| pc_i | input | 15 | Program counter to be saved |
| irq_req_i | input | 3 | Request pulses: bit 0 external, bit 1 timer 0, bit 2 timer 1 |
| irq_en_i | input | 3 | Per-source enables, same bit order |
| tos_o | output | 15 | Newest stored address (0 when empty) |
| full_o | output | 1 | All levels in use |
| pend_o | output | 3 | Latched request flags |
| ack_o | output | 1 | One-cycle interrupt acknowledge |
| ack_id_o | output | 2 | Index of the acknowledged source |

## Verification
The stack is filled, overfilled by one and drained against a last-in first-out model that drops its oldest entry. This separates correct wrap-around from a pointer that saturates or corrupts. Every nonzero enable mask is swept with all three requests pending, and the expected winner is computed as the lowest set bit. This separates priority errors from flag-clearing errors. Timed request sequences cover several cases: a full stack followed by a pop, a cleared global enable followed by a return-from-interrupt, and a call in the same cycle as a pending request. These show whether the acknowledge lands in exactly the predicted cycle or leaks early.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
  localparam int unsigned STK_DEPTH = 8;
  localparam int unsigned PCW       = 15;
  localparam int unsigned NSRC      = 3;

  typedef enum logic [1:0] {
    SRC_EXT  = 2'd0,
    SRC_TMR0 = 2'd1,
    SRC_TMR1 = 2'd2
  } src_e;
endpackage

// File: rtl/rsg_lifo.sv
module rsg_lifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned PC_W  = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_i,
  input  logic            pop_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] tos_o,
  output logic            full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  logic [PC_W-1:0]  mem [DEPTH];
  logic [PTR_W-1:0] wp;
  logic [CNT_W-1:0] cnt;
  logic             pop_ok;

  function automatic logic [PTR_W-1:0] p_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_MAX) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] p_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_MAX : p - PTR_W'(1);
  endfunction

  assign pop_ok = pop_i && !push_i && (cnt != '0);

  // storage without reset so it can map onto memory primitives
  always_ff @(posedge clk) begin
    if (push_i) mem[wp] <= pc_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      cnt    <= '0;
      full_o <= 1'b0;
      tos_o  <= '0;
    end else if (push_i) begin
      wp     <= p_inc(wp);
      if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
      full_o <= (cnt >= CNT_MAX - CNT_W'(1));
      tos_o  <= pc_i;
    end else if (pop_ok) begin
      wp     <= p_dec(wp);
      cnt    <= cnt - CNT_W'(1);
      full_o <= 1'b0;
      tos_o  <= (cnt == CNT_W'(1)) ? '0 : mem[p_dec(p_dec(wp))];
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_MAX); // R1
  AST_FULL_TRACKS_CNT: assert property (@(posedge clk) disable iff (rst)
    full_o == (cnt == CNT_MAX)); // R1
  AST_WRAP_KEEPS_FULL: assert property (@(posedge clk) disable iff (rst)
    (full_o && push_i) |=> full_o); // R8
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0 && pop_i && !push_i) |=> (cnt == '0 && $stable(tos_o))); // R5
endmodule

// File: rtl/rsg_gate.sv
module rsg_gate #(
  parameter int unsigned N_SRC = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_SRC-1:0]         req_i,
  input  logic [N_SRC-1:0]         en_i,
  input  logic                     full_i,
  input  logic                     busy_i,
  input  logic                     reti_i,
  output logic                     fire_o,
  output logic                     ack_o,
  output logic [$clog2(N_SRC)-1:0] ack_id_o,
  output logic [N_SRC-1:0]         pend_o
);
  localparam int unsigned ID_W = $clog2(N_SRC);

  logic [N_SRC-1:0] cand;
  logic [N_SRC-1:0] win;
  logic [ID_W-1:0]  win_id;
  logic             gie;

  assign cand = pend_o & en_i;

  // lowest index wins: scan from the top so the lowest overwrites last
  always_comb begin
    win    = '0;
    win_id = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (cand[i]) begin
        win    = '0;
        win[i] = 1'b1;
        win_id = ID_W'(i);
      end
    end
  end

  assign fire_o = gie && !full_i && !busy_i && (cand != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o   <= '0;
      gie      <= 1'b1;
      ack_o    <= 1'b0;
      ack_id_o <= '0;
    end else begin
      pend_o <= (pend_o & ~(fire_o ? win : '0)) | req_i;
      ack_o  <= fire_o;
      if (fire_o) begin
        gie      <= 1'b0;
        ack_id_o <= win_id;
      end else if (reti_i) begin
        gie <= 1'b1;
      end
    end
  end

  AST_ACK_NEEDS_ROOM: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(!full_i)); // R7
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o); // R9
  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win)); // R10
  AST_QUIET_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> !ack_o); // R12
endmodule

// File: rtl/rsg_top.sv
module rsg_top
  import rsg_pkg::*;
#(
  parameter int unsigned DEPTH = STK_DEPTH,
  parameter int unsigned PC_W  = PCW,
  parameter int unsigned N_SRC = NSRC
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     call_i,
  input  logic                     ret_i,
  input  logic                     reti_i,
  input  logic [PC_W-1:0]          pc_i,
  input  logic [N_SRC-1:0]         irq_req_i,
  input  logic [N_SRC-1:0]         irq_en_i,
  output logic [PC_W-1:0]          tos_o,
  output logic                     full_o,
  output logic [N_SRC-1:0]         pend_o,
  output logic                     ack_o,
  output logic [$clog2(N_SRC)-1:0] ack_id_o
);
  logic fire;
  logic push;
  logic pop;
  logic busy;
  logic reti_eff;

  assign busy     = call_i | ret_i | reti_i;
  assign push     = call_i | fire;
  assign pop      = ret_i | reti_i;
  assign reti_eff = reti_i & ~call_i;

  rsg_lifo #(.DEPTH(DEPTH), .PC_W(PC_W)) u_lifo (
    .clk    (clk),
    .rst    (rst),
    .push_i (push),
    .pop_i  (pop),
    .pc_i   (pc_i),
    .tos_o  (tos_o),
    .full_o (full_o)
  );

  rsg_gate #(.N_SRC(N_SRC)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .req_i    (irq_req_i),
    .en_i     (irq_en_i),
    .full_i   (full_o),
    .busy_i   (busy),
    .reti_i   (reti_eff),
    .fire_o   (fire),
    .ack_o    (ack_o),
    .ack_id_o (ack_id_o),
    .pend_o   (pend_o)
  );

  AST_PUSH_SHOWS_PC: assert property (@(posedge clk) disable iff (rst)
    call_i |=> (tos_o == $past(pc_i))); // R2
endmodule

// File: tb/rsg_top_bench.sv
module rsg_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        call_i = 0, ret_i = 0, reti_i = 0;
  logic [14:0] pc_i = '0;
  logic [2:0]  irq_req_i = '0, irq_en_i = '0;
  logic [14:0] tos_o;
  logic        full_o, ack_o;
  logic [2:0]  pend_o;
  logic [1:0]  ack_id_o;

  int checks = 0;
  int errs   = 0;
  bit done   = 0;
  logic [14:0] mdl[$];

  always #5 clk = ~clk;

  rsg_top u_rsg_top (.*);

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic logic [14:0] exp_tos();
    return (mdl.size() > 0) ? mdl[mdl.size()-1] : 15'd0;
  endfunction

  task automatic m_push(logic [14:0] v);
    if (mdl.size() == 8) void'(mdl.pop_front());
    mdl.push_back(v);
  endtask

  task automatic m_pop();
    if (mdl.size() > 0) void'(mdl.pop_back());
  endtask

  task automatic chk_stack(string req);
    chk(tos_o == exp_tos(), req, "tos", tos_o, exp_tos());
    chk(full_o == (mdl.size() == 8), req, "full", full_o, mdl.size() == 8);
  endtask

  task automatic do_reset();
    rst = 1; cyc(); cyc(); rst = 0;
    mdl.delete();
  endtask

  task automatic do_call(logic [14:0] v);
    call_i = 1; pc_i = v; cyc(); call_i = 0;
    m_push(v);
  endtask

  task automatic do_pop(bit intr);
    if (intr) reti_i = 1; else ret_i = 1;
    cyc(); ret_i = 0; reti_i = 0;
    m_pop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    cyc();
    do_reset();
    // R4 reset state
    chk(tos_o == 0 && full_o == 0, "R4", "stack", {full_o, tos_o}, 0);
    chk(pend_o == 0 && ack_o == 0, "R4", "irq", {pend_o, ack_o}, 0);

    // R1 R2 fill to capacity
    for (int i = 0; i < 8; i++) begin
      do_call(15'h100 + 15'(i));
      chk_stack("R2");
    end
    chk(full_o == 1, "R1", "full after 8", full_o, 1);
    // R8 overfill wraps onto oldest
    do_call(15'h200);
    chk_stack("R8");
    // R3 drain in LIFO order
    for (int i = 0; i < 8; i++) begin
      do_pop(0);
      chk_stack("R3");
    end
    // R5 pop on empty ignored
    do_pop(0);
    chk_stack("R5");
    do_call(15'h055);
    chk_stack("R5");
    do_pop(0);
    chk_stack("R5");

    // R6 external request, acknowledge timing
    irq_en_i = 3'b111; pc_i = 15'h300;
    irq_req_i = 3'b001; cyc(); irq_req_i = 0;
    chk(pend_o == 3'b001 && ack_o == 0, "R6", "latched", {pend_o, ack_o}, 4'b0010);
    cyc(); m_push(15'h300);
    chk(ack_o == 1 && ack_id_o == 0, "R6", "ack", {ack_o, ack_id_o}, 3'b100);
    chk(pend_o == 0, "R6", "cleared", pend_o, 0);
    chk_stack("R6");
    cyc();
    chk(ack_o == 0, "R6", "pulse width", ack_o, 0);

    // R9 global enable cleared until reti
    irq_req_i = 3'b010; cyc(); irq_req_i = 0;
    cyc(); cyc();
    chk(ack_o == 0 && pend_o == 3'b010, "R9", "held", {pend_o, ack_o}, 4'b0100);
    pc_i = 15'h321;
    do_pop(1);
    chk(ack_o == 0, "R9", "ack in reti cycle", ack_o, 0);
    chk_stack("R9");
    cyc(); m_push(15'h321);
    chk(ack_o == 1 && ack_id_o == 1, "R9", "ack after reti", {ack_o, ack_id_o}, 3'b101);
    chk_stack("R9");
    do_pop(1);

    // R11 disabled source stays pending
    irq_en_i = 3'b000; irq_req_i = 3'b100; cyc(); irq_req_i = 0;
    cyc(); cyc();
    chk(ack_o == 0 && pend_o == 3'b100, "R11", "masked", {pend_o, ack_o}, 4'b1000);
    irq_en_i = 3'b100; pc_i = 15'h0AB; cyc(); m_push(15'h0AB);
    chk(ack_o == 1 && ack_id_o == 2, "R11", "unmasked ack", {ack_o, ack_id_o}, 3'b110);
    chk_stack("R11");
    do_pop(1);

    // R10 priority sweep over every enable mask
    for (int m = 1; m < 8; m++) begin
      automatic int id = (m & 1) ? 0 : ((m & 2) ? 1 : 2);
      do_reset();
      irq_en_i = 3'(m); irq_req_i = 3'b111; pc_i = 15'(m); cyc(); irq_req_i = 0;
      cyc();
      chk(ack_o == 1 && ack_id_o == 2'(id), "R10", "winner", {ack_o, ack_id_o}, 4 | id);
      chk(pend_o == (3'b111 & ~(3'b001 << id)), "R10", "flags", pend_o, 7 & ~(1 << id));
    end

    // R7 full stack withholds acknowledge
    do_reset();
    irq_en_i = 0;
    for (int i = 0; i < 8; i++) do_call(15'h400 + 15'(i));
    irq_en_i = 3'b001; irq_req_i = 3'b001; cyc(); irq_req_i = 0;
    cyc(); cyc();
    chk(ack_o == 0 && pend_o == 3'b001 && full_o == 1, "R7", "withheld",
        {full_o, pend_o, ack_o}, 5'b10010);
    pc_i = 15'h4AA;
    do_pop(0);
    chk(ack_o == 0 && full_o == 0, "R7", "after pop", {full_o, ack_o}, 0);
    cyc(); m_push(15'h4AA);
    chk(ack_o == 1 && ack_id_o == 0, "R7", "released ack", {ack_o, ack_id_o}, 3'b100);
    chk_stack("R7");

    // R12 call beats ret, strobes block acknowledge
    do_reset();
    irq_en_i = 3'b001;
    call_i = 1; ret_i = 1; pc_i = 15'h111; cyc(); call_i = 0; ret_i = 0;
    m_push(15'h111);
    chk_stack("R12");
    irq_req_i = 3'b001; cyc(); irq_req_i = 0;
    do_call(15'h222);
    chk(ack_o == 0 && pend_o == 3'b001, "R12", "deferred", {pend_o, ack_o}, 4'b0010);
    chk_stack("R12");
    pc_i = 15'h233; cyc(); m_push(15'h233);
    chk(ack_o == 1, "R12", "ack after strobe", ack_o, 1);
    chk_stack("R12");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule